// File: doc/BRIEF.md
# ADC Acquisition Control Registers

This block is the register-mapped controller for a multi-channel sampling ADC front end. A host reaches it through a plain 32-bit register port: one write or read strobe, an 8-bit byte offset and 32-bit data. Through this port the host programs a channel configuration word and a channel number, then launches either a one-shot run of conversions or a timer-paced continuous run. Every conversion raises a request on a converter handshake port. The matching acknowledge carries a 16-bit result, and the block pushes that result into a 16-entry sample FIFO.

When the programmed number of conversions completes, the block sets an end-of-sequence flag, which clears when the host reads it. It also sets an interrupt flag that drives the `irq` pin and is cleared by writing back a value with its bit set. The pacing timer counts in one of three time units. The units come from a fixed prescaler derived from the system clock frequency: clock periods, microseconds or milliseconds.

Offsets used below: 0x00 channel target, 0x04 mode, 0x08 run control, 0x0C FIFO control/status, 0x10 interrupt flag, 0x14 end-of-sequence, 0x1C sample pop, 0x20 timer reload, 0x24 time unit, 0x30 conversions per sequence. Any other offset reads as zero.

Top module: `adc_acq_ctrl`

## Requirements
- R1: After reset, every register reads 0, the FIFO is empty, and `cnv_req` and `irq` are low.
- R2: A write to 0x00 is steered by bit 8 of the mode register (0x04, bits 8:0 read/write). With bit 8 clear, the word goes to the configuration register, which keeps only bits 7, 6, 1 and 0: bits 1:0 and 6 form the range code and bit 7 marks differential input. With bit 8 set, the low 4 bits go to the channel number. A read of 0x00 returns whichever of the two is currently selected. The configuration and channel number appear on `cnv_cfg` and `cnv_chan`.
- R3: While acquisition is active, writes to 0x00 are ignored.
- R4: A write to 0x08 with bit 19 set and bit 20 clear starts a one-shot run of N back-to-back conversions, where N is the value at 0x30 and a value of 0 counts as 1. The run stops by itself when the N conversions are done. A write to 0x08 without bit 19 stops acquisition and drops `cnv_req`. Reading 0x08 shows bit 19 while active and bit 20 while in timed mode.
- R5: `cnv_req` stays high until `cnv_ack`. On the acknowledge, `cnv_result` is pushed into the FIFO and `cnv_req` goes low for at least one cycle.
- R6: Each read of 0x1C returns the oldest sample in bits 15:0 and pops it. A read of an empty FIFO returns 0 and changes nothing. Reading 0x0C gives the fill count in bits 4:0 and the sticky overflow flag in bit 8.
- R7: A push into a full FIFO with no pop in the same cycle is dropped and sets the overflow flag. A write to 0x0C with bit 16 set empties the FIFO and clears the overflow flag.
- R8: Bit 0 of 0x14 is set when a sequence completes and is cleared by reading 0x14; that read still returns 1.
- R9: Bit 1 of 0x10 and the `irq` pin are set when a sequence completes. A write to 0x10 with bit 1 set clears them; a write with bit 1 clear leaves them unchanged. If a completion and a clear fall in the same cycle, the flag stays set.
- R10: A write to 0x08 with bits 19 and 20 both set starts timed mode. The timer expires every max(R,1) units, where R is the 16-bit value at 0x20. The unit is set at 0x24: code 0 is one clock period, code 1 is CLK_MHZ clocks, and codes 2 and 3 are 1000·CLK_MHZ clocks. Each expiry launches one conversion.
- R11: In timed mode, end-of-sequence and the interrupt flag are set after every N conversions, and acquisition keeps running until it is stopped.
- R12: A push and a pop in the same cycle on a full FIFO both take effect: the count stays 16 and the overflow flag stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects occur at the clock edge) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| cnv_req | output | 1 | Conversion request to the converter |
| cnv_chan | output | 4 | Selected channel number |
| cnv_cfg | output | 8 | Channel configuration word |
| cnv_ack | input | 1 | Converter acknowledge, one cycle |
| cnv_result | input | 16 | Conversion result, valid with `cnv_ack` |
| irq | output | 1 | Interrupt flag |

## Verification
The converter acknowledge pushing a result and a host read popping the FIFO can fall in the same cycle. To provoke this, the bench fills the FIFO to 16 entries and then takes over the converter port. It raises `cnv_ack` on exactly the cycle in which it issues a read of 0x1C. The outcome is judged at the ports: the read returns the old head, the status still shows 16 entries with no overflow, and draining the FIFO brings out the acknowledged value last.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;
   localparam int ADDR_W = 8;
   localparam int REG_W  = 32;

   localparam logic [ADDR_W-1:0] OFS_CHSEL   = 8'h00;
   localparam logic [ADDR_W-1:0] OFS_MODE    = 8'h04;
   localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h08;
   localparam logic [ADDR_W-1:0] OFS_FIFOCTL = 8'h0C;
   localparam logic [ADDR_W-1:0] OFS_IRQ     = 8'h10;
   localparam logic [ADDR_W-1:0] OFS_EOS     = 8'h14;
   localparam logic [ADDR_W-1:0] OFS_DATA    = 8'h1C;
   localparam logic [ADDR_W-1:0] OFS_RELOAD  = 8'h20;
   localparam logic [ADDR_W-1:0] OFS_UNIT    = 8'h24;
   localparam logic [ADDR_W-1:0] OFS_NSEQ    = 8'h30;

   localparam int MODE_W       = 9;
   localparam int MODE_SEL_BIT = 8;
   localparam int GO_BIT       = 19;
   localparam int TMR_BIT      = 20;
   localparam int FLUSH_BIT    = 16;
   localparam int IRQ_BIT      = 1;
   localparam int EOS_BIT      = 0;
   localparam int OVF_BIT      = 8;
   localparam logic [7:0] CFG_KEEP = 8'hC3;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_WAIT = 2'd1,
      SQ_REQ  = 2'd2
   } sq_state_e;

   typedef enum logic [1:0] {
      TU_FINE  = 2'd0,
      TU_MICRO = 2'd1,
      TU_MILLI = 2'd2
   } tunit_e;
endpackage

// File: rtl/adc_unit_timer.sv
module adc_unit_timer #(
   parameter int CLK_MHZ = 250,
   parameter int TMR_W   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [1:0]       unit,
   input  logic [TMR_W-1:0] reload,
   output logic             expire
);
   import adc_acq_pkg::*;

   localparam int US_W   = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
   localparam int MS_DIV = 1000;
   localparam int MS_W   = $clog2(MS_DIV);

   if (CLK_MHZ < 1 || TMR_W < 2) begin : g_bad_cfg
      $error("adc_unit_timer: CLK_MHZ must be >= 1 and TMR_W >= 2");
   end

   logic             hold;
   logic             us_tick;
   logic             ms_tick;
   logic             unit_tick;
   logic [MS_W-1:0]  ms_cnt_q;
   logic [TMR_W-1:0] tcnt_q;
   logic [TMR_W-1:0] reload_eff;

   assign hold       = restart || !run;
   assign reload_eff = (reload == '0) ? TMR_W'(1) : reload;

   if (CLK_MHZ == 1) begin : g_us_direct
      assign us_tick = !hold;
   end else begin : g_us_div
      logic [US_W-1:0] us_cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 us_cnt_q <= '0;
         else if (hold)                              us_cnt_q <= '0;
         else if (us_cnt_q == US_W'(CLK_MHZ - 1))    us_cnt_q <= '0;
         else                                        us_cnt_q <= us_cnt_q + 1'b1;
      end
      assign us_tick = !hold && (us_cnt_q == US_W'(CLK_MHZ - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    ms_cnt_q <= '0;
      else if (hold)                                 ms_cnt_q <= '0;
      else if (us_tick) begin
         if (ms_cnt_q == MS_W'(MS_DIV - 1))          ms_cnt_q <= '0;
         else                                        ms_cnt_q <= ms_cnt_q + 1'b1;
      end
   end
   assign ms_tick = us_tick && (ms_cnt_q == MS_W'(MS_DIV - 1));

   always_comb begin
      case (unit)
         TU_FINE:  unit_tick = !hold;
         TU_MICRO: unit_tick = us_tick;
         default:  unit_tick = ms_tick;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  tcnt_q <= TMR_W'(1);
      else if (hold)               tcnt_q <= reload_eff;
      else if (unit_tick) begin
         if (tcnt_q == TMR_W'(1))  tcnt_q <= reload_eff;
         else                      tcnt_q <= tcnt_q - 1'b1;
      end
   end

   assign expire = unit_tick && (tcnt_q == TMR_W'(1));

   // R10
   reload_after_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (tcnt_q == $past(reload_eff)));
endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic             pop,
   input  logic [W-1:0]     din,
   output logic [W-1:0]     dout,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty,
   output logic             ovf
);
   localparam int  AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit  POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("adc_sample_fifo: DEPTH must be >= 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [AW-1:0]    wr_ptr_q, rd_ptr_q, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic             pop_ok, push_ok, drop;

   if (POW2) begin : g_wrap_natural
      assign wr_nxt = wr_ptr_q + 1'b1;
      assign rd_nxt = rd_ptr_q + 1'b1;
   end else begin : g_wrap_compare
      assign wr_nxt = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      assign rd_nxt = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
   end

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign pop_ok  = pop && !empty;
   assign push_ok = push && (!full || pop_ok);
   assign drop    = push && full && !pop_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
         ovf_q    <= 1'b0;
      end else if (flush) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
         ovf_q    <= 1'b0;
      end else begin
         if (push_ok) wr_ptr_q <= wr_nxt;
         if (pop_ok)  rd_ptr_q <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
         if (drop) ovf_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok && !flush) mem[wr_ptr_q] <= din;
   end

   assign dout  = empty ? '0 : mem[rd_ptr_q];
   assign count = cnt_q;
   assign ovf   = ovf_q;

   // R7
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> (full && ovf));
   // R12
   push_pop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && full && !flush) |=> (full && $stable(ovf)));
   // R6
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !flush) |=> empty);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
   parameter int SEQ_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_wr,
   input  logic             go_bit,
   input  logic             tmr_bit,
   input  logic             expire,
   input  logic [SEQ_W-1:0] seq_len,
   input  logic             cnv_ack,
   output logic             cnv_req,
   output logic             push,
   output logic             seq_done,
   output logic             active,
   output logic             timed
);
   import adc_acq_pkg::*;

   if (SEQ_W < 1 || SEQ_W > REG_W) begin : g_bad_seq
      $error("adc_conv_seq: SEQ_W must be within 1..32");
   end

   sq_state_e        st_q;
   logic             timed_q;
   logic             pend_q;
   logic [SEQ_W-1:0] n_q;
   logic [SEQ_W-1:0] target;
   logic [SEQ_W:0]   n_inc;
   logic             last;
   logic             consume;

   assign target  = (seq_len == '0) ? SEQ_W'(1) : seq_len;
   assign n_inc   = {1'b0, n_q} + 1'b1;
   assign last    = (n_inc >= {1'b0, target});
   assign consume = (st_q == SQ_WAIT) && (!timed_q || pend_q);

   assign active   = (st_q != SQ_IDLE);
   assign timed    = timed_q;
   assign cnv_req  = (st_q == SQ_REQ);
   assign push     = cnv_req && cnv_ack && !go_wr;
   assign seq_done = push && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         timed_q <= 1'b0;
         pend_q  <= 1'b0;
         n_q     <= '0;
      end else if (go_wr) begin
         st_q    <= go_bit ? SQ_WAIT : SQ_IDLE;
         timed_q <= go_bit && tmr_bit;
         pend_q  <= 1'b0;
         n_q     <= '0;
      end else begin
         pend_q <= timed_q && active && (expire || (pend_q && !consume));
         case (st_q)
            SQ_WAIT: if (consume) st_q <= SQ_REQ;
            SQ_REQ: begin
               if (cnv_ack) begin
                  if (last) begin
                     n_q  <= '0;
                     st_q <= timed_q ? SQ_WAIT : SQ_IDLE;
                  end else begin
                     n_q  <= n_q + 1'b1;
                     st_q <= SQ_WAIT;
                  end
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnv_req && !cnv_ack && !go_wr) |=> cnv_req);
   // R5
   req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> !cnv_req);
   // R4
   single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_done && !timed_q) |=> !active);
   // R11
   timed_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_done && timed_q) |=> active);
endmodule

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl #(
   parameter int CLK_MHZ    = 250,
   parameter int CH_NUM     = 16,
   parameter int FIFO_DEPTH = 16,
   parameter int DATA_W     = 16,
   parameter int TMR_W      = 16,
   parameter int SEQ_W      = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_wr,
   input  logic                       reg_rd,
   input  logic [7:0]                 reg_addr,
   input  logic [31:0]                reg_wdata,
   output logic [31:0]                reg_rdata,
   output logic                       cnv_req,
   output logic [$clog2(CH_NUM)-1:0]  cnv_chan,
   output logic [7:0]                 cnv_cfg,
   input  logic                       cnv_ack,
   input  logic [DATA_W-1:0]          cnv_result,
   output logic                       irq
);
   import adc_acq_pkg::*;

   localparam int CH_W  = $clog2(CH_NUM);
   localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

   if (CH_NUM < 2 || DATA_W > REG_W || TMR_W > REG_W || CNT_W > OVF_BIT) begin : g_bad_top
      $error("adc_acq_ctrl: parameter out of range");
   end

   logic [MODE_W-1:0] mode_q;
   logic [7:0]        cfg_q;
   logic [CH_W-1:0]   chan_q;
   logic [TMR_W-1:0]  reload_q;
   logic [1:0]        unit_q;
   logic [SEQ_W-1:0]  nseq_q;
   logic              eos_q;
   logic              irq_q;

   logic              go_wr, flush, pop, active, timed, push, seq_done, expire;
   logic [DATA_W-1:0] fifo_dout;
   logic [CNT_W-1:0]  fifo_cnt;
   logic              fifo_full, fifo_empty, fifo_ovf;
   logic              unused_sink;

   assign unused_sink = ^{reg_wdata, fifo_full, fifo_empty};

   assign go_wr = reg_wr && (reg_addr == OFS_CTRL);
   assign flush = reg_wr && (reg_addr == OFS_FIFOCTL) && reg_wdata[FLUSH_BIT];
   assign pop   = reg_rd && (reg_addr == OFS_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= '0;
         cfg_q    <= '0;
         chan_q   <= '0;
         reload_q <= '0;
         unit_q   <= '0;
         nseq_q   <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            OFS_CHSEL: begin
               if (!active) begin
                  if (mode_q[MODE_SEL_BIT]) chan_q <= reg_wdata[CH_W-1:0];
                  else                      cfg_q  <= reg_wdata[7:0] & CFG_KEEP;
               end
            end
            OFS_MODE:   mode_q   <= reg_wdata[MODE_W-1:0];
            OFS_RELOAD: reload_q <= reg_wdata[TMR_W-1:0];
            OFS_UNIT:   unit_q   <= reg_wdata[1:0];
            OFS_NSEQ:   nseq_q   <= reg_wdata[SEQ_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eos_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         if (seq_done)                                     eos_q <= 1'b1;
         else if (reg_rd && reg_addr == OFS_EOS)           eos_q <= 1'b0;
         if (seq_done)                                     irq_q <= 1'b1;
         else if (reg_wr && reg_addr == OFS_IRQ && reg_wdata[IRQ_BIT]) irq_q <= 1'b0;
      end
   end

   adc_conv_seq #(.SEQ_W(SEQ_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .go_wr    (go_wr),
      .go_bit   (reg_wdata[GO_BIT]),
      .tmr_bit  (reg_wdata[TMR_BIT]),
      .expire   (expire),
      .seq_len  (nseq_q),
      .cnv_ack  (cnv_ack),
      .cnv_req  (cnv_req),
      .push     (push),
      .seq_done (seq_done),
      .active   (active),
      .timed    (timed)
   );

   adc_unit_timer #(.CLK_MHZ(CLK_MHZ), .TMR_W(TMR_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (go_wr),
      .run     (active && timed),
      .unit    (unit_q),
      .reload  (reload_q),
      .expire  (expire)
   );

   adc_sample_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (push),
      .pop   (pop),
      .din   (cnv_result),
      .dout  (fifo_dout),
      .count (fifo_cnt),
      .full  (fifo_full),
      .empty (fifo_empty),
      .ovf   (fifo_ovf)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_CHSEL: begin
            if (mode_q[MODE_SEL_BIT]) reg_rdata[CH_W-1:0] = chan_q;
            else                      reg_rdata[7:0]      = cfg_q;
         end
         OFS_MODE:    reg_rdata[MODE_W-1:0] = mode_q;
         OFS_CTRL: begin
            reg_rdata[GO_BIT]  = active;
            reg_rdata[TMR_BIT] = timed;
         end
         OFS_FIFOCTL: begin
            reg_rdata[CNT_W-1:0] = fifo_cnt;
            reg_rdata[OVF_BIT]   = fifo_ovf;
         end
         OFS_IRQ:     reg_rdata[IRQ_BIT]     = irq_q;
         OFS_EOS:     reg_rdata[EOS_BIT]     = eos_q;
         OFS_DATA:    reg_rdata[DATA_W-1:0]  = fifo_dout;
         OFS_RELOAD:  reg_rdata[TMR_W-1:0]   = reload_q;
         OFS_UNIT:    reg_rdata[1:0]         = unit_q;
         OFS_NSEQ:    reg_rdata[SEQ_W-1:0]   = nseq_q;
         default: ;
      endcase
   end

   assign cnv_chan = chan_q;
   assign cnv_cfg  = cfg_q;
   assign irq      = irq_q;

   // R3
   cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && reg_wr && reg_addr == OFS_CHSEL) |=> ($stable(cfg_q) && $stable(chan_q)));
   // R8
   eos_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == OFS_EOS && !seq_done) |=> !eos_q);
   // R9
   irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> irq);
   // R9
   irq_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFS_IRQ && reg_wdata[IRQ_BIT] && !seq_done) |=> !irq);
endmodule

// File: tb/adc_acq_ctrl_tb_top.sv
module adc_acq_ctrl_tb_top;
   import adc_acq_pkg::*;

   localparam int TB_MHZ = 8;
   localparam int US_CYC = TB_MHZ;
   localparam int MS_CYC = 1000 * TB_MHZ;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cnv_req;
   logic [3:0]  cnv_chan;
   logic [7:0]  cnv_cfg;
   logic        cnv_ack = 1'b0;
   logic [15:0] cnv_result = '0;
   logic        irq;

   int          n_chk = 0;
   int          n_err = 0;
   int unsigned cyc = 0;
   bit          resp_en = 1'b1;
   int          ack_dly = 2;
   logic [15:0] resp_val = 16'h0000;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   adc_acq_ctrl #(.CLK_MHZ(TB_MHZ)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cnv_req(cnv_req), .cnv_chan(cnv_chan), .cnv_cfg(cnv_cfg),
      .cnv_ack(cnv_ack), .cnv_result(cnv_result), .irq(irq)
   );

   // converter model
   initial begin
      forever begin
         @(negedge clk);
         if (cnv_req && resp_en) begin
            repeat (ack_dly) @(negedge clk);
            if (cnv_req && resp_en) begin
               cnv_ack    = 1'b1;
               cnv_result = resp_val;
               resp_val   = resp_val + 16'h0101;
               @(negedge clk);
               cnv_ack = 1'b0;
            end
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      int k;
      k = 0;
      v = 32'h0008_0000;
      while (v[GO_BIT] && k < 3000) begin
         rd(OFS_CTRL, v);
         k++;
      end
   endtask

   task automatic next_rise(output int unsigned t);
      int lim;
      lim = 0;
      while (cnv_req && lim < 40000) begin @(negedge clk); lim++; end
      while (!cnv_req && lim < 40000) begin @(negedge clk); lim++; end
      t = cyc;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      // R1
      check("R1 req", {31'b0, cnv_req}, 32'd0);
      check("R1 irq", {31'b0, irq}, 32'd0);
      rd(OFS_CHSEL, v);   check("R1 chsel", v, 32'd0);
      rd(OFS_MODE, v);    check("R1 mode", v, 32'd0);
      rd(OFS_CTRL, v);    check("R1 ctrl", v, 32'd0);
      rd(OFS_FIFOCTL, v); check("R1 fifo", v, 32'd0);
      rd(OFS_EOS, v);     check("R1 eos", v, 32'd0);
      rd(OFS_NSEQ, v);    check("R1 nseq", v, 32'd0);
   endtask

   task automatic t_steer();
      logic [31:0] v;
      // R2
      wr(OFS_MODE, 32'hFFFF_FFFF);
      rd(OFS_MODE, v); check("R2 mode width", v, 32'h1FF);
      wr(OFS_MODE, 32'h0);
      wr(OFS_CHSEL, 32'h0000_0047);
      rd(OFS_CHSEL, v); check("R2 cfg mask", v, 32'h43);
      check("R2 cfg pin", {24'b0, cnv_cfg}, 32'h43);
      wr(OFS_MODE, 32'h100);
      wr(OFS_CHSEL, 32'h0000_0025);
      rd(OFS_CHSEL, v); check("R2 chan", v, 32'h5);
      check("R2 chan pin", {28'b0, cnv_chan}, 32'h5);
      check("R2 cfg kept", {24'b0, cnv_cfg}, 32'h43);
      wr(OFS_MODE, 32'h0);
   endtask

   task automatic t_single();
      logic [31:0] v;
      wr(OFS_FIFOCTL, 32'h0001_0000);
      wr(OFS_NSEQ, 32'd3);
      resp_val = 16'h1000;
      wr(OFS_CTRL, 32'h0008_0000);
      rd(OFS_CTRL, v); check("R4 active bit", v, 32'h0008_0000);
      wait_idle();
      check("R4 stops", {31'b0, cnv_req}, 32'd0);
      rd(OFS_FIFOCTL, v); check("R4 three results", v, 32'd3);
      rd(OFS_DATA, v); check("R6 pop0", v, 32'h1000);
      rd(OFS_DATA, v); check("R6 pop1", v, 32'h1101);
      rd(OFS_DATA, v); check("R6 pop2", v, 32'h1202);
      rd(OFS_DATA, v); check("R6 empty pop", v, 32'h0);
      rd(OFS_FIFOCTL, v); check("R6 empty count", v, 32'h0);
      rd(OFS_EOS, v); check("R8 eos set", v, 32'h1);
      rd(OFS_EOS, v); check("R8 eos cleared", v, 32'h0);
      check("R9 irq pin", {31'b0, irq}, 32'd1);
      wr(OFS_IRQ, 32'h0000_0001);
      rd(OFS_IRQ, v); check("R9 no clear", v, 32'h2);
      wr(OFS_IRQ, 32'h0000_0002);
      rd(OFS_IRQ, v); check("R9 cleared", v, 32'h0);
      check("R9 irq pin low", {31'b0, irq}, 32'd0);
      // R4 zero count acts as one
      wr(OFS_NSEQ, 32'd0);
      wr(OFS_CTRL, 32'h0008_0000);
      wait_idle();
      rd(OFS_FIFOCTL, v); check("R4 zero as one", v, 32'd1);
      wr(OFS_FIFOCTL, 32'h0001_0000);
      rd(OFS_EOS, v);
      wr(OFS_IRQ, 32'h2);
   endtask

   task automatic t_hold_stop();
      logic [31:0] v;
      resp_en = 1'b0;
      wr(OFS_NSEQ, 32'd1);
      wr(OFS_CTRL, 32'h0008_0000);
      repeat (20) @(negedge clk);
      check("R5 req held", {31'b0, cnv_req}, 32'd1);
      wr(OFS_CTRL, 32'h0);
      check("R4 stop drops req", {31'b0, cnv_req}, 32'd0);
      rd(OFS_CTRL, v); check("R4 stopped", v, 32'h0);
      rd(OFS_FIFOCTL, v); check("R5 no push", v, 32'h0);
      resp_en = 1'b1;
   endtask

   task automatic t_lock();
      logic [31:0] v;
      wr(OFS_MODE, 32'h0);
      wr(OFS_CHSEL, 32'h03);
      resp_en = 1'b0;
      wr(OFS_CTRL, 32'h0008_0000);
      wr(OFS_CHSEL, 32'hC0);
      rd(OFS_CHSEL, v); check("R3 cfg locked", v, 32'h03);
      wr(OFS_MODE, 32'h100);
      wr(OFS_CHSEL, 32'h9);
      rd(OFS_CHSEL, v); check("R3 chan locked", v, 32'h5);
      wr(OFS_CTRL, 32'h0);
      wr(OFS_CHSEL, 32'h9);
      rd(OFS_CHSEL, v); check("R3 unlocked", v, 32'h9);
      wr(OFS_MODE, 32'h0);
      resp_en = 1'b1;
   endtask

   task automatic t_overflow();
      logic [31:0] v;
      wr(OFS_FIFOCTL, 32'h0001_0000);
      wr(OFS_NSEQ, 32'd18);
      resp_val = 16'h2000;
      wr(OFS_CTRL, 32'h0008_0000);
      wait_idle();
      rd(OFS_FIFOCTL, v); check("R7 full with ovf", v, 32'h110);
      rd(OFS_DATA, v); check("R7 oldest kept", v, 32'h2000);
      wr(OFS_FIFOCTL, 32'h0001_0000);
      rd(OFS_FIFOCTL, v); check("R7 flush", v, 32'h0);
      rd(OFS_EOS, v);
      wr(OFS_IRQ, 32'h2);
   endtask

   task automatic t_push_pop_full();
      logic [31:0] v;
      logic [15:0] e;
      int lim;
      wr(OFS_NSEQ, 32'd16);
      resp_val = 16'h3000;
      wr(OFS_CTRL, 32'h0008_0000);
      wait_idle();
      rd(OFS_FIFOCTL, v); check("R12 filled", v, 32'h010);
      resp_en = 1'b0;
      wr(OFS_NSEQ, 32'd1);
      wr(OFS_CTRL, 32'h0008_0000);
      lim = 0;
      while (!cnv_req && lim < 100) begin @(negedge clk); lim++; end
      @(negedge clk);
      cnv_ack = 1'b1; cnv_result = 16'hBEEF;
      reg_rd = 1'b1; reg_addr = OFS_DATA;
      #1 v = reg_rdata;
      @(negedge clk);
      cnv_ack = 1'b0; reg_rd = 1'b0;
      check("R12 head popped", v, 32'h3000);
      rd(OFS_FIFOCTL, v); check("R12 count kept no ovf", v, 32'h010);
      e = 16'h3000;
      for (int k = 1; k < 16; k++) begin
         e = e + 16'h0101;
         rd(OFS_DATA, v);
         if (k == 15) check("R12 order", v, {16'b0, e});
      end
      rd(OFS_DATA, v); check("R12 pushed last", v, 32'h0000_BEEF);
      resp_en = 1'b1;
      wait_idle();
      rd(OFS_EOS, v);
      wr(OFS_IRQ, 32'h2);
   endtask

   task automatic t_timed(input int unsigned unit, input int unsigned rel,
                          input int unsigned exp_gap, input string tag);
      logic [31:0] v;
      int unsigned t1, t2;
      wr(OFS_FIFOCTL, 32'h0001_0000);
      rd(OFS_EOS, v);
      wr(OFS_IRQ, 32'h2);
      wr(OFS_UNIT, unit);
      wr(OFS_RELOAD, rel);
      wr(OFS_NSEQ, 32'd2);
      wr(OFS_CTRL, 32'h0018_0000);
      next_rise(t1);
      next_rise(t2);
      check(tag, t2 - t1, exp_gap);
      repeat (8) @(negedge clk);
      rd(OFS_CTRL, v); check("R11 still running", v, 32'h0018_0000);
      rd(OFS_EOS, v); check("R11 eos after pair", v, 32'h1);
      check("R11 irq", {31'b0, irq}, 32'd1);
      wr(OFS_CTRL, 32'h0);
      rd(OFS_CTRL, v); check("R4 timed stopped", v, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_steer();
      t_single();
      t_hold_stop();
      t_lock();
      t_overflow();
      t_push_pop_full();
      t_timed(0, 12, 12, "R10 clock unit gap");
      t_timed(1, 3, 3 * US_CYC, "R10 micro unit gap");
      t_timed(1, 0, US_CYC, "R10 zero reload");
      t_timed(2, 1, MS_CYC, "R10 milli unit gap");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule